// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two unsigned operands and a carry input. It returns the sum and a carry output, and it holds no state. The operand width is split into equal slices. The lowest slice is a ripple chain of full adders driven by the real carry input. Every higher slice is built twice: one copy assumes no incoming carry and the other assumes an incoming carry. Both copies start as soon as the operands settle.

The carry that comes out of each slice goes through a short chain of 2:1 multiplexers. Each stage takes the carry chosen for the slice below and uses it to pick which of its own two candidate results is passed on. The longest path is one slice of ripple followed by one multiplexer per higher slice. A ripple chain across the full width would be longer. The cost is about twice the adder hardware in the upper slices.

The width and the slice width are parameters, and the slice width must divide the total width. By default the block is a 16-bit adder built from 4-bit slices.

Top module: `carrySelectAdder`

## Requirements
- R1: For every input, the concatenation {cout,sum} equals the arithmetic value opA + opB + cin, taken to WIDTH+1 bits.
- R2: The lowest slice gives its sum bits and slice carry from the low SLICE bits of both operands plus cin, with the carry rippling bit by bit. With opA=0x000F, opB=0x0000 and cin=1, sum is 0x0010.
- R3: In every upper slice, the candidate that assumes an incoming carry has a sum equal to the other candidate's sum plus one, modulo 2^SLICE. Its carry equals the other candidate's carry OR'd with "the other candidate's sum is all ones".
- R4: The carry into each upper slice is the carry chosen for the slice directly below it, and that carry picks the slice's candidate. A carry produced in slice 0 must travel through every upper slice that propagates it: 0x0FFF + 0x0001 gives 0x1000, and 0x7FFF + 0x0001 gives 0x8000.
- R5: cout is the carry chosen for the top slice. It is 1 exactly when the true sum exceeds 2^WIDTH - 1.
- R6: With all-ones operands and cin=1, the result is sum=all ones and cout=1. With all-ones opA, zero opB and cin=1, the result is sum=0 and cout=1.
- R7: With zero operands, sum equals cin (zero-extended) and cout is 0.
- R8: The block is purely combinational. Outputs follow the inputs within the same time step and depend on no clock or earlier input.
- R9: Any configuration in which SLICE divides WIDTH and there are at least two slices is correct in the sense of R1. This includes WIDTH=6 with SLICE=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The assertions are evaluated every time the inputs change:
- the lowest slice's ripple result against arithmetic;
- the plus-one relation between each pair of candidates, including their carries;
- the behaviour of the select chain whenever both candidates agree, or when one candidate kills or generates the carry;
- the full result against a reference addition.

Only the bench's scenarios can show the following:
- that carries crossing several slice boundaries arrive at the correct bit positions;
- that the all-ones and zero corners give the values listed in R6 and R7;
- that a second, small configuration is correct over its whole input space.

// File: rtl/csaPkg.sv
package csaPkg;

  // Carry results of the two precomputed copies of one upper slice.
  typedef struct packed {
    logic noCarry;   // carry out when the slice carry-in is 0
    logic withCarry; // carry out when the slice carry-in is 1
  } candCarry_t;

endpackage

// File: rtl/csaRippleSlice.sv
module csaRippleSlice #(
  parameter int W = 4
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);

  logic [W:0] chain;

  assign chain[0] = carryIn;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic halfSum;
    assign halfSum      = opA[i] ^ opB[i];
    assign sumOut[i]    = halfSum ^ chain[i];
    assign chain[i + 1] = (opA[i] & opB[i]) | (halfSum & chain[i]);
  end

  assign carryOut = chain[W];

endmodule

// File: rtl/csaDatapath.sv
module csaDatapath
  import csaPkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SLICE = 4,
  localparam int NUM_SLICES = WIDTH / SLICE,
  localparam int NUM_UPPER  = NUM_SLICES - 1
) (
  input  logic [WIDTH-1:0]           opA,
  input  logic [WIDTH-1:0]           opB,
  input  logic                       cin,
  input  logic [NUM_UPPER-1:0]       upperCin,
  output candCarry_t [NUM_UPPER-1:0] candCarry,
  output logic                       lowCarry,
  output logic [WIDTH-1:0]           sum
);

  // Lowest slice: plain ripple from the real carry input.
  logic [SLICE-1:0] lowSum;

  csaRippleSlice #(.W(SLICE)) i_lowSlice (
    .opA     (opA[SLICE-1:0]),
    .opB     (opB[SLICE-1:0]),
    .carryIn (cin),
    .sumOut  (lowSum),
    .carryOut(lowCarry)
  );

  assign sum[SLICE-1:0] = lowSum;

  always_comb begin
    AST_LOW_SLICE: assert ({lowCarry, lowSum} ==
        (SLICE + 1)'(opA[SLICE-1:0]) + (SLICE + 1)'(opB[SLICE-1:0]) + (SLICE + 1)'(cin))
      else $error("low slice ripple mismatch"); // R2
  end

  // Upper slices: two copies each, steered by the chosen carry.
  for (genvar k = 1; k < NUM_SLICES; k++) begin : g_upper
    localparam int LO = k * SLICE;
    logic [SLICE-1:0] sumNoC;
    logic [SLICE-1:0] sumWithC;
    logic             carryNoC;
    logic             carryWithC;

    csaRippleSlice #(.W(SLICE)) i_sliceNoC (
      .opA     (opA[LO +: SLICE]),
      .opB     (opB[LO +: SLICE]),
      .carryIn (1'b0),
      .sumOut  (sumNoC),
      .carryOut(carryNoC)
    );

    csaRippleSlice #(.W(SLICE)) i_sliceWithC (
      .opA     (opA[LO +: SLICE]),
      .opB     (opB[LO +: SLICE]),
      .carryIn (1'b1),
      .sumOut  (sumWithC),
      .carryOut(carryWithC)
    );

    assign candCarry[k-1].noCarry   = carryNoC;
    assign candCarry[k-1].withCarry = carryWithC;
    assign sum[LO +: SLICE] = upperCin[k-1] ? sumWithC : sumNoC;

    always_comb begin
      AST_CAND_STEP: assert (sumWithC == SLICE'(sumNoC + 1'b1))
        else $error("candidate sums not one apart"); // R3
      AST_CAND_CARRY: assert (carryWithC == (carryNoC | (&sumNoC)))
        else $error("candidate carries inconsistent"); // R3
    end
  end

endmodule

// File: rtl/csaSelectChain.sv
module csaSelectChain
  import csaPkg::*;
#(
  parameter int NUM_UPPER = 3
) (
  input  logic                       lowCarry,
  input  candCarry_t [NUM_UPPER-1:0] candCarry,
  output logic [NUM_UPPER-1:0]       upperCin,
  output logic                       cout
);

  // chosen[k] is the carry into upper slice k; chosen[NUM_UPPER] leaves the top.
  logic [NUM_UPPER:0] chosen;

  assign chosen[0] = lowCarry;

  for (genvar k = 0; k < NUM_UPPER; k++) begin : g_stage
    assign chosen[k + 1] = chosen[k] ? candCarry[k].withCarry : candCarry[k].noCarry;

    always_comb begin
      AST_SEL_AGREE: assert ((candCarry[k].noCarry != candCarry[k].withCarry) ||
                             (chosen[k + 1] == candCarry[k].noCarry))
        else $error("select output differs from agreeing candidates"); // R4
      AST_SEL_GEN: assert (!candCarry[k].noCarry || chosen[k + 1])
        else $error("generated carry lost"); // R4
      AST_SEL_KILL: assert (candCarry[k].withCarry || !chosen[k + 1])
        else $error("killed carry appeared"); // R4
    end
  end

  assign upperCin = chosen[NUM_UPPER-1:0];
  assign cout     = chosen[NUM_UPPER];

endmodule

// File: rtl/carrySelectAdder.sv
module carrySelectAdder
  import csaPkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NUM_SLICES = WIDTH / SLICE;
  localparam int NUM_UPPER  = NUM_SLICES - 1;

  if ((WIDTH % SLICE) != 0 || NUM_SLICES < 2) begin : g_badCfg
    $error("SLICE must divide WIDTH into at least two slices");
  end

  candCarry_t [NUM_UPPER-1:0] candCarry;
  logic [NUM_UPPER-1:0]       upperCin;
  logic                       lowCarry;

  csaDatapath #(.WIDTH(WIDTH), .SLICE(SLICE)) i_datapath (
    .opA      (opA),
    .opB      (opB),
    .cin      (cin),
    .upperCin (upperCin),
    .candCarry(candCarry),
    .lowCarry (lowCarry),
    .sum      (sum)
  );

  csaSelectChain #(.NUM_UPPER(NUM_UPPER)) i_selectChain (
    .lowCarry (lowCarry),
    .candCarry(candCarry),
    .upperCin (upperCin),
    .cout     (cout)
  );

  always_comb begin
    AST_FULL_SUM: assert ({cout, sum} ==
        (WIDTH + 1)'(opA) + (WIDTH + 1)'(opB) + (WIDTH + 1)'(cin))
      else $error("adder result mismatch"); // R1
  end

endmodule

// File: tb/test_carrySelectAdder.sv
module test_carrySelectAdder;

  localparam int W  = 16;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  sum;
  logic          cout;

  logic [SW-1:0] sA = '0;
  logic [SW-1:0] sB = '0;
  logic          sCin = 1'b0;
  logic [SW-1:0] sSum;
  logic          sCout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  carrySelectAdder #(.WIDTH(W), .SLICE(4)) i_carrySelectAdder (
    .opA(opA), .opB(opB), .cin(cin), .sum(sum), .cout(cout)
  );

  carrySelectAdder #(.WIDTH(SW), .SLICE(2)) i_smallAdder (
    .opA(sA), .opB(sB), .cin(sCin), .sum(sSum), .cout(sCout)
  );

  task automatic checkMain(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic c, input string tag);
    logic [W:0] expv;
    @(negedge clk);
    opA = a; opB = b; cin = c;
    #1;
    expv = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    checks++;
    if ({cout, sum} !== expv) begin
      failures++;
      $display("FAIL %s: a=%h b=%h cin=%0b got=%h expected=%h", tag, a, b, c, {cout, sum}, expv);
    end
  endtask

  task automatic checkSmall(input logic [SW-1:0] a, input logic [SW-1:0] b, input logic c);
    logic [SW:0] expv;
    @(negedge clk);
    sA = a; sB = b; sCin = c;
    #1;
    expv = {1'b0, a} + {1'b0, b} + {{SW{1'b0}}, c};
    checks++;
    if ({sCout, sSum} !== expv) begin
      failures++;
      $display("FAIL R9: a=%h b=%h cin=%0b got=%h expected=%h", a, b, c, {sCout, sSum}, expv);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Idle state: zero inputs give zero outputs (R7)
    checkMain(16'h0000, 16'h0000, 1'b0, "R7 idle");
    checkMain(16'h0000, 16'h0000, 1'b1, "R7 zero with cin");
    checkMain(16'h000F, 16'h0000, 1'b1, "R2 low slice carry");
    checkMain(16'h0007, 16'h0009, 1'b0, "R2 low slice generate");
    checkMain(16'h00F0, 16'h0010, 1'b0, "R3 slice1 candidate");
    checkMain(16'h0FFF, 16'h0001, 1'b0, "R4 two-slice propagate");
    checkMain(16'h7FFF, 16'h0001, 1'b0, "R4 three-slice propagate");
    checkMain(16'h8000, 16'h8000, 1'b0, "R5 top carry only");
    checkMain(16'hFFFF, 16'h0000, 1'b1, "R5 full ripple");
    checkMain(16'hFFFF, 16'hFFFF, 1'b1, "R6 all ones cin");
    checkMain(16'hFFFF, 16'h0000, 1'b1, "R6 all ones plus cin");
    checkMain(16'hAAAA, 16'h5555, 1'b0, "R1 alternating");
    checkMain(16'hAAAA, 16'h5555, 1'b1, "R1 alternating cin");
    checkMain(16'h5555, 16'h5555, 1'b1, "R1 alternating same");
    checkMain(16'hAAAA, 16'hAAAA, 1'b0, "R1 alternating high");
    // R8: new inputs show up at once, regardless of what came before
    checkMain(16'h1234, 16'h4321, 1'b0, "R8 immediate");
    checkMain(16'h1234, 16'h4321, 1'b1, "R8 cin toggle");
    for (int i = 0; i < 3000; i++) begin
      checkMain(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
    end
    // R9: exhaustive sweep of the small configuration
    for (int a = 0; a < (1 << SW); a++) begin
      for (int b = 0; b < (1 << SW); b++) begin
        for (int c = 0; c < 2; c++) begin
          checkSmall(SW'(a), SW'(b), c[0]);
        end
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule